// File: doc/BRIEF.md
# Host Bus Error Monitor

This block sits beside a host-bus bridge and watches for trouble. It samples three active-low error pins (address error, bus error, bus init) and three internal error pulses (protocol violation, request parity, address parity). Every event it sees is logged in a status register that software clears by writing ones. A command register sets how each event is reported. An event can raise a system-error pulse or a hard-fail request, depending on one select bit. A bus error can also make the block drive bus-init, and parity errors can make it drive bus-error.

The block also holds a bus watchdog. It runs while a transaction is outstanding and no response phase has been seen. When it expires, the block gives a one-cycle timeout pulse, which the read datapath uses to return all ones. The timeout is logged in status whether or not it is reported. Enables captured from configuration straps at reset, plus a global system-error enable, further gate reporting.

Top module: `hb_err_monitor`

## Requirements
- R1: After reset the status register reads 0x00000000, the command register reads 0x00000010, and every output pulse is low.
- R2: Writing the status register clears each bit written as 1. Bits written as 0 keep their value. Writes to the command register store only bits 2, 3, 4, 6, 7, 8, 9, 10 and 13.
- R3: A new low level on aerr_n, berr_n or binit_n sets status bit 0, 2 or 3 respectively. The binit_n event is logged only while cap_binit_en is 1. A pin held low logs once: if software clears the bit while the pin stays low, the bit stays clear.
- R4: A high level on prot_viol, req_par_err or addr_par_err at a clock edge sets status bit 16, 18 or 19 respectively.
- R5: An address-error event is reported only when command bit 6, cap_aerr_en and serr_en are all 1.
- R6: A bus-error event is reported only when command bit 7 and cap_berr_en are both 1. serr_en plays no part.
- R7: With command bit 4 set, a bus-error event pulses binit_o. With command bit 3 set, prot_viol pulses binit_o.
- R8: With command bit 2 set, req_par_err or addr_par_err pulses berr_o.
- R9: A reported event pulses serr_o when command bit 13 is 0 and hard_fail_o when it is 1. The two never pulse together.
- R10: With command bit 8 set, ioq_busy high and resp_seen low, the watchdog expires PRESCALE*SHORT_TICKS clocks after it starts. Expiry gives a one-cycle tmo_o and sets status bit 9. The timeout is also reported if command bit 9 is 1.
- R11: With command bit 10 set, the watchdog period is PRESCALE*LONG_TICKS clocks.
- R12: The watchdog restarts from zero on any cycle with resp_seen high, with ioq_busy low, or with command bit 8 clear. With bit 8 clear it never expires.
- R13: Each newly detected event yields a single-cycle output pulse, even while an error pin stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aerr_n | input | 1 | Address error pin, active low |
| berr_n | input | 1 | Bus error pin, active low |
| binit_n | input | 1 | Bus init pin, active low |
| prot_viol | input | 1 | Protocol violation pulse |
| req_par_err | input | 1 | Request parity error pulse |
| addr_par_err | input | 1 | Address parity error pulse |
| ioq_busy | input | 1 | In-order queue holds an outstanding transaction |
| resp_seen | input | 1 | Response phase observed this cycle |
| cap_aerr_en | input | 1 | Strap-captured address-error input enable |
| cap_berr_en | input | 1 | Strap-captured bus-error input enable |
| cap_binit_en | input | 1 | Strap-captured bus-init input enable |
| serr_en | input | 1 | Global system-error enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| serr_o | output | 1 | System-error pulse |
| hard_fail_o | output | 1 | Hard-fail request pulse |
| binit_o | output | 1 | Drive bus-init pulse |
| berr_o | output | 1 | Drive bus-error pulse |
| tmo_o | output | 1 | Watchdog timeout pulse (force all-ones read data) |
| status_o | output | 32 | Error status register |

## Verification
A pin is sampled by one flop and edge-detected against a second, so pin results appear after the second clock edge that sees the pin low. The bench drives pins at a falling edge, waits two rising edges and samples 1 ns later. It then confirms the pulse has gone after one more edge. The internal pulse inputs and register writes act at the first rising edge, so those checks sample just after that edge. Watchdog checks count rising edges from the falling edge that raises ioq_busy and require tmo_o exactly on edge PRESCALE times the selected tick count.

// File: rtl/hb_err_monitor.sv
module hb_err_monitor #(
  parameter int PRESCALE    = 16,
  parameter int SHORT_TICKS = 8,
  parameter int LONG_TICKS  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        aerr_n,
  input  logic        berr_n,
  input  logic        binit_n,
  input  logic        prot_viol,
  input  logic        req_par_err,
  input  logic        addr_par_err,
  input  logic        ioq_busy,
  input  logic        resp_seen,
  input  logic        cap_aerr_en,
  input  logic        cap_berr_en,
  input  logic        cap_binit_en,
  input  logic        serr_en,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        serr_o,
  output logic        hard_fail_o,
  output logic        binit_o,
  output logic        berr_o,
  output logic        tmo_o,
  output logic [31:0] status_o
);

  localparam logic [31:0] CMD_RST   = 32'h0000_0010;
  localparam logic [31:0] CMD_MASK  = 32'h0000_27DC;
  localparam logic [31:0] STAT_MASK = 32'h000D_020D;
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int TW = $clog2(LONG_TICKS + 1);

  logic [31:0]   cmd_q, stat_q, stat_set, stat_clr;
  logic [2:0]    pin_s, pin_d, pin_ev;
  logic [PW-1:0] pre_q;
  logic [TW-1:0] tick_q, limit;
  logic          wdog_run, tick, expire;
  logic          aerr_rep, berr_rep, tmo_rep, report;

  assign pin_ev   = pin_s & ~pin_d;
  assign wdog_run = cmd_q[8] & ioq_busy & ~resp_seen;
  assign tick     = wdog_run && (pre_q == PW'(PRESCALE - 1));
  assign limit    = cmd_q[10] ? TW'(LONG_TICKS) : TW'(SHORT_TICKS);
  assign expire   = tick && (tick_q == limit - TW'(1));

  assign aerr_rep = pin_ev[0] & cmd_q[6] & cap_aerr_en & serr_en;
  assign berr_rep = pin_ev[1] & cmd_q[7] & cap_berr_en;
  assign tmo_rep  = expire & cmd_q[9];
  assign report   = aerr_rep | berr_rep | tmo_rep;

  always_comb begin
    stat_set     = '0;
    stat_set[0]  = pin_ev[0];
    stat_set[2]  = pin_ev[1];
    stat_set[3]  = pin_ev[2] & cap_binit_en;
    stat_set[9]  = expire;
    stat_set[16] = prot_viol;
    stat_set[18] = req_par_err;
    stat_set[19] = addr_par_err;
  end

  assign stat_clr  = (reg_wr && reg_sel) ? reg_wdata : '0;
  assign reg_rdata = reg_sel ? stat_q : cmd_q;
  assign status_o  = stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_s <= '0;
      pin_d <= '0;
    end else begin
      pin_s <= {~binit_n, ~berr_n, ~aerr_n};
      pin_d <= pin_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= CMD_RST;
      stat_q <= '0;
    end else begin
      if (reg_wr && !reg_sel) cmd_q <= reg_wdata & CMD_MASK;
      stat_q <= ((stat_q & ~stat_clr) | stat_set) & STAT_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !wdog_run) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (tick) begin
      pre_q  <= '0;
      tick_q <= expire ? '0 : tick_q + TW'(1);
    end else begin
      pre_q  <= pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      serr_o      <= 1'b0;
      hard_fail_o <= 1'b0;
      binit_o     <= 1'b0;
      berr_o      <= 1'b0;
      tmo_o       <= 1'b0;
    end else begin
      serr_o      <= report & ~cmd_q[13];
      hard_fail_o <= report & cmd_q[13];
      binit_o     <= (pin_ev[1] & cmd_q[4]) | (prot_viol & cmd_q[3]);
      berr_o      <= (req_par_err | addr_par_err) & cmd_q[2];
      tmo_o       <= expire;
    end
  end

endmodule

module hb_err_monitor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cmd,
  input logic [31:0] status,
  input logic        serr,
  input logic        hard_fail,
  input logic        binit,
  input logic        tmo,
  input logic        prot_viol
);

  p_reset_vals_r1: assert property (@(posedge clk)
    !rst_n |=> (status == 32'h0 && cmd == 32'h10));

  p_prot_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[16]) |-> $past(prot_viol));

  p_route_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(serr && hard_fail));

  p_serr_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
    serr |-> !$past(cmd[13]));

  p_hf_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hard_fail |-> $past(cmd[13]));

  p_binit_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    binit |-> ($past(cmd[4]) || $past(cmd[3])));

  p_tmo_logged_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[9]) |-> tmo);

  p_tmo_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !tmo);

  p_tmo_needs_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> $past(cmd[8]));

endmodule

bind hb_err_monitor hb_err_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd_q), .status(stat_q),
  .serr(serr_o), .hard_fail(hard_fail_o), .binit(binit_o),
  .tmo(tmo_o), .prot_viol(prot_viol)
);

// File: tb/hb_err_monitor_test.sv
module hb_err_monitor_test;
  localparam int P = 16, S = 8, L = 32;

  logic clk = 0, rst_n = 0;
  logic aerr_n = 1, berr_n = 1, binit_n = 1;
  logic prot_viol = 0, req_par_err = 0, addr_par_err = 0;
  logic ioq_busy = 0, resp_seen = 0;
  logic cap_aerr_en = 1, cap_berr_en = 1, cap_binit_en = 1, serr_en = 1;
  logic reg_wr = 0, reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, status_o;
  logic serr_o, hard_fail_o, binit_o, berr_o, tmo_o;
  int total = 0, fails = 0;
  logic done = 0;

  always #2 clk = ~clk;

  hb_err_monitor #(.PRESCALE(P), .SHORT_TICKS(S), .LONG_TICKS(L)) uut (
    .clk(clk), .rst_n(rst_n), .aerr_n(aerr_n), .berr_n(berr_n), .binit_n(binit_n),
    .prot_viol(prot_viol), .req_par_err(req_par_err), .addr_par_err(addr_par_err),
    .ioq_busy(ioq_busy), .resp_seen(resp_seen), .cap_aerr_en(cap_aerr_en),
    .cap_berr_en(cap_berr_en), .cap_binit_en(cap_binit_en), .serr_en(serr_en),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .serr_o(serr_o), .hard_fail_o(hard_fail_o), .binit_o(binit_o), .berr_o(berr_o),
    .tmo_o(tmo_o), .status_o(status_o));

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [31:0] v);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = v;
    @(negedge clk); reg_wr = 0; reg_sel = 0; reg_wdata = 0;
  endtask

  // pin: 0 aerr, 1 berr, 2 binit; returns {serr,hf,binit,berr,tmo} on the due cycle
  task automatic pin_hit(int pin, output logic [4:0] o, input bit hold = 0);
    @(negedge clk);
    if (pin == 0) aerr_n = 0; else if (pin == 1) berr_n = 0; else binit_n = 0;
    @(posedge clk); @(posedge clk); #1;
    o = {serr_o, hard_fail_o, binit_o, berr_o, tmo_o};
    if (!hold) begin
      @(negedge clk); aerr_n = 1; berr_n = 1; binit_n = 1;
    end
  endtask

  task automatic t_reset;
    chk("R1 status after reset", status_o, 32'h0);
    chk("R1 command after reset", reg_rdata, 32'h10);
    chk("R1 outputs after reset", {serr_o, hard_fail_o, binit_o, berr_o, tmo_o}, 0);
  endtask

  task automatic t_aerr;
    logic [4:0] o;
    pin_hit(0, o);
    chk("R3 aerr logs bit 0", status_o[0], 1);
    chk("R5 aerr unreported with cmd6 clear", o[4], 0);
    wr(1, 32'hFFFF_FFFE);
    chk("R2 write 0 keeps bit 0", status_o[0], 1);
    wr(1, 32'h1);
    chk("R2 write 1 clears bit 0", status_o, 0);
    wr(0, 32'hFFFF_FFFF);
    chk("R2 command writable bits", reg_rdata, 32'h27DC);
    wr(0, 32'h50);
    pin_hit(0, o);
    chk("R5 aerr reported on serr", o[4:3], 2'b10);
    @(posedge clk); #1;
    chk("R13 serr single cycle", serr_o, 0);
    serr_en = 0;
    pin_hit(0, o);
    chk("R5 aerr blocked by serr_en", o[4], 0);
    serr_en = 1; cap_aerr_en = 0;
    pin_hit(0, o);
    chk("R5 aerr blocked by strap", o[4], 0);
    cap_aerr_en = 1;
    wr(0, 32'h2050);
    pin_hit(0, o);
    chk("R9 aerr routed to hard fail", o[4:3], 2'b01);
    wr(0, 32'h10);
    wr(1, 32'hFFFF_FFFF);
  endtask

  task automatic t_berr;
    logic [4:0] o;
    pin_hit(1, o);
    chk("R7 berr drives binit by default", o[2], 1);
    chk("R6 berr unreported with cmd7 clear", o[4], 0);
    chk("R3 berr logs bit 2", status_o, 32'h4);
    wr(0, 32'h80);
    serr_en = 0;
    pin_hit(1, o);
    chk("R6 berr reported, serr_en ignored", o[4:2], 3'b100);
    serr_en = 1; cap_berr_en = 0;
    pin_hit(1, o);
    chk("R6 berr blocked by strap", o[4], 0);
    cap_berr_en = 1;
    wr(1, 32'hFFFF_FFFF);
    pin_hit(1, o, 1);
    chk("R13 held pin pulses once", o[4], 1);
    wr(1, 32'h4);
    repeat (4) @(posedge clk); #1;
    chk("R3 held pin not relogged", status_o[2], 0);
    chk("R13 no repeat serr while held", serr_o, 0);
    @(negedge clk); berr_n = 1;
    cap_binit_en = 0;
    pin_hit(2, o);
    chk("R3 binit ignored with strap clear", status_o, 0);
    cap_binit_en = 1;
    pin_hit(2, o);
    chk("R3 binit logs bit 3", status_o, 32'h8);
    wr(0, 32'h10);
    wr(1, 32'hFFFF_FFFF);
  endtask

  task automatic t_pulses;
    @(negedge clk); prot_viol = 1;
    @(posedge clk); #1;
    chk("R4 protocol violation logs bit 16", status_o, 32'h1_0000);
    chk("R7 no binit with cmd3 clear", binit_o, 0);
    @(negedge clk); prot_viol = 0;
    wr(0, 32'h0C);
    @(negedge clk); prot_viol = 1;
    @(posedge clk); #1;
    chk("R7 protocol violation drives binit", binit_o, 1);
    @(negedge clk); prot_viol = 0; req_par_err = 1;
    @(posedge clk); #1;
    chk("R8 request parity drives berr", berr_o, 1);
    chk("R4 request parity logs bit 18", status_o[18], 1);
    @(negedge clk); req_par_err = 0; addr_par_err = 1;
    @(posedge clk); #1;
    chk("R4 address parity logs bit 19", status_o[19], 1);
    chk("R8 address parity drives berr", berr_o, 1);
    @(negedge clk); addr_par_err = 0;
    wr(0, 32'h0);
    @(negedge clk); req_par_err = 1;
    @(posedge clk); #1;
    chk("R8 no berr with cmd2 clear", berr_o, 0);
    @(negedge clk); req_par_err = 0;
    wr(1, 32'hFFFF_FFFF);
    chk("R2 full clear", status_o, 0);
  endtask

  task automatic wait_tmo(int maxc, output int n, output logic s);
    n = 0; s = 0;
    for (int i = 1; i <= maxc; i++) begin
      @(posedge clk); #1;
      if (tmo_o && n == 0) begin n = i; s = serr_o; end
    end
  endtask

  task automatic t_wdog;
    int n; logic s;
    wr(0, 32'h100);
    @(negedge clk); ioq_busy = 1;
    wait_tmo(P*S + 5, n, s);
    chk("R10 short timeout cycle", n, P*S);
    chk("R10 timeout unreported with cmd9 clear", s, 0);
    chk("R10 timeout logged", status_o[9], 1);
    @(negedge clk); ioq_busy = 0;
    wr(1, 32'h200);
    wr(0, 32'h300);
    @(negedge clk); ioq_busy = 1;
    wait_tmo(P*S + 5, n, s);
    chk("R10 reported timeout on serr", s, 1);
    @(negedge clk); ioq_busy = 0;
    wr(0, 32'h500);
    @(negedge clk); ioq_busy = 1;
    wait_tmo(P*L + 5, n, s);
    chk("R11 long timeout cycle", n, P*L);
    @(negedge clk); ioq_busy = 0;
    wr(0, 32'h100);
    @(negedge clk); ioq_busy = 1;
    repeat (P*S - 10) @(posedge clk);
    @(negedge clk); resp_seen = 1;
    @(negedge clk); resp_seen = 0;
    wait_tmo(P*S + 5, n, s);
    chk("R12 response restarts watchdog", n, P*S);
    @(negedge clk); ioq_busy = 0;
    wr(0, 32'h0);
    wr(1, 32'hFFFF_FFFF);
    @(negedge clk); ioq_busy = 1;
    wait_tmo(2*P*L, n, s);
    chk("R12 no timeout with cmd8 clear", n, 0);
    chk("R12 nothing logged when disabled", status_o, 0);
    @(negedge clk); ioq_busy = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    t_reset();
    t_aerr();
    t_berr();
    t_pulses();
    t_wdog();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule